// File: doc/BRIEF.md
# Dual-Role Pin Serial Configuration Target

This block is a serial-bus target that fills and reads back a configuration store of sixteen bytes (128 bits in all). The store's contents leave the block as one flat vector that drives the clock-generation logic beside it. Two device pins each have two jobs, and a strap input picks the job. With the strap low (program mode), one pin is the serial clock and the other is the open-drain serial data line. With the strap high (run mode), the same two pins are plain level inputs: a power-down request and an output-enable request.

Both pins are sampled with the system clock through synchronizers. In program mode the target finds START and STOP conditions and matches a 7-bit address set by a parameter. The first byte written after the address loads a register pointer. Later bytes are written to the store at the pointer, or read from it, and the pointer advances after each byte and wraps. The target pulls the data line low to acknowledge, and it never drives it high. In run mode the bus logic is held idle and the pins are decoded as the two control outputs.

Top module: `cfgbus_target`

## Requirements
- R1: With `mode_i` high (run mode), `pd_o` follows the clock/power-down pin level and `oe_o` follows the data/output-enable pin level, within 3 clock cycles. With `mode_i` low (program mode), both outputs are 0.
- R2: While `mode_i` is high, any bus activity on the pins is ignored. `sda_pull_o` stays 0 and `cfg_o` does not change.
- R3: The target acknowledges an address byte only when its upper 7 bits equal `TARGET_ADDR`. The address byte is sent MSB first, and its bit 0 is the direction (1 = read, 0 = write). To acknowledge, the target holds the data line low through the 9th clock. On a mismatch it gives no acknowledge and writes nothing until the next START.
- R4: After a write address, the first byte loads the pointer from its low 4 bits. Each following byte is written to the store at the pointer. The target acknowledges every byte it accepts.
- R5: The pointer advances by one after each byte written, and after each byte loaded for a read. It wraps from 15 to 0.
- R6: After a read address, the target shifts out the store byte at the pointer, MSB first. It sends another byte when the master acknowledges (data low on the 9th clock). After a not-acknowledge (data high) it stops driving until the next START.
- R7: A START in any state restarts address reception and drops any partly received byte. A repeated START keeps the pointer.
- R8: Store byte k appears on `cfg_o[8k+7:8k]`. Reset clears every byte to 0.
- R9: `sda_pull_o` changes only while the synchronized serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Strap: 0 = program mode, 1 = run mode |
| pd_scl_i | input | 1 | Pin level: serial clock in program mode, power-down request in run mode |
| oe_sda_i | input | 1 | Pin level as seen on the wire: serial data in program mode, output-enable request in run mode |
| sda_pull_o | output | 1 | Open-drain pull-down request for the data pin (1 = pull low) |
| pd_o | output | 1 | Decoded power-down control |
| oe_o | output | 1 | Decoded output-enable control |
| cfg_o | output | 128 | Flattened configuration store |

## Verification
A wrong bit counter or phase shows at the ports within the same byte, as an acknowledge in the wrong bit slot or a missing one. The master sees it at the 9th clock of that byte. A wrong pointer shows one byte later: the data lands in the wrong field of `cfg_o` or comes back in a readback. The wrap tests expose a bad wrap as a misplaced third byte. A leak of bus logic into run mode shows either as a pull on the data pin, which is watched on every cycle, or as a change in `cfg_o` after a full transaction sent while the strap is high.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  // address byte carries the target address in bits 7:1, direction in bit 0
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/cfgbus_store.sv
module cfgbus_store #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CFG_W = DEPTH * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_data,
  output logic [CFG_W-1:0] cfg_o
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (wr_en) begin
      cells[wr_ptr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_ptr];

  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign cfg_o[8*k +: 8] = cells[k];
  end

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h58,
  parameter int         DEPTH       = 16,
  localparam int        PTR_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_mode,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             sda_s,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sda_pull
);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  phase_e           phase;
  logic [3:0]       cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic             in_ack;
  logic             mack_n;
  logic [PTR_W-1:0] ptr;

  logic byte_in_done;
  assign byte_in_done = scl_fall && (cnt == 4'd8);

  assign wr_en = !run_mode && !start_ev && !stop_ev && !in_ack &&
                 (phase == PH_WDATA) && byte_in_done;
  assign wr_data = rx_sh;
  assign ptr_o   = ptr;

  assign sda_pull = !run_mode && (in_ack || (phase == PH_RDATA && !tx_sh[7]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      rx_sh  <= '0;
      tx_sh  <= '1;
      in_ack <= 1'b0;
      mack_n <= 1'b1;
      ptr    <= '0;
    end else if (run_mode) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      tx_sh  <= '1;
      in_ack <= 1'b0;
    end else if (start_ev) begin
      phase  <= PH_ADDR;
      cnt    <= '0;
      tx_sh  <= '1;
      in_ack <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      tx_sh  <= '1;
      in_ack <= 1'b0;
    end else if (in_ack) begin
      if (scl_fall) begin
        in_ack <= 1'b0;
        cnt    <= '0;
        if (phase == PH_RDATA) begin
          tx_sh <= rd_data;
          ptr   <= ptr_next(ptr);
        end
      end
    end else begin
      unique case (phase)
        PH_ADDR, PH_PTR, PH_WDATA: begin
          if (scl_rise && cnt < 4'd8) begin
            rx_sh <= {rx_sh[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end
          if (byte_in_done) begin
            if (phase == PH_ADDR) begin
              if (addr_hit(rx_sh, TARGET_ADDR)) begin
                in_ack <= 1'b1;
                phase  <= rx_sh[0] ? PH_RDATA : PH_PTR;
              end else begin
                phase <= PH_IDLE;
              end
            end else if (phase == PH_PTR) begin
              ptr    <= rx_sh[PTR_W-1:0];
              in_ack <= 1'b1;
              phase  <= PH_WDATA;
            end else begin
              ptr    <= ptr_next(ptr);
              in_ack <= 1'b1;
            end
          end
        end
        PH_RDATA: begin
          if (scl_rise && cnt < 4'd9) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd8) mack_n <= sda_s;
          end
          if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd8) begin
              tx_sh <= {tx_sh[6:0], 1'b1};
            end else if (cnt == 4'd9) begin
              if (!mack_n) begin
                tx_sh <= rd_data;
                ptr   <= ptr_next(ptr);
                cnt   <= '0;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfgbus_target.sv
module cfgbus_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h58,
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(DEPTH),
  localparam int        CFG_W       = DEPTH * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             pd_scl_i,
  input  logic             oe_sda_i,
  output logic             sda_pull_o,
  output logic             pd_o,
  output logic             oe_o,
  output logic [CFG_W-1:0] cfg_o
);

  logic [1:0] pins_s;
  logic       scl_s, sda_s, scl_q, sda_q;

  cfgbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pd_scl_i, oe_sda_i}),
    .q_o   (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      pd_o  <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      pd_o  <= mode_i & scl_s;
      oe_o  <= mode_i & sda_s;
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;

  logic             wr_en;
  logic [7:0]       wr_data, rd_data;
  logic [PTR_W-1:0] ptr;

  cfgbus_engine #(.TARGET_ADDR(TARGET_ADDR), .DEPTH(DEPTH)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_mode (mode_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (sda_s),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr_o    (ptr),
    .sda_pull (sda_pull_o)
  );

  cfgbus_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ptr  (ptr),
    .wr_data (wr_data),
    .rd_ptr  (ptr),
    .rd_data (rd_data),
    .cfg_o   (cfg_o)
  );

endmodule

// File: rtl/cfgbus_target_chk.sv
module cfgbus_target_chk #(
  parameter int PTR_W = 4,
  parameter int CFG_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_i,
  input logic             sda_pull_o,
  input logic             pd_o,
  input logic             oe_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             scl_s,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr
);

  AST_PROG_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_i) |-> (!pd_o && !oe_o)) else $error("program-mode controls not low"); // R1

  AST_RUN_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |-> !sda_pull_o) else $error("pull while in run mode"); // R2

  AST_RUN_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> $stable(cfg_o)) else $error("store changed in run mode"); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == PTR_W'($past(ptr) + 1'b1))) else $error("pointer did not step"); // R5

  AST_PULL_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull_o != $past(sda_pull_o)) && !mode_i && !$past(mode_i) &&
     !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_s))
    else $error("pull changed while clock high"); // R9

endmodule

bind cfgbus_target cfgbus_target_chk #(.PTR_W(PTR_W), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .sda_pull_o (sda_pull_o),
  .pd_o       (pd_o),
  .oe_o       (oe_o),
  .cfg_o      (cfg_o),
  .scl_s      (scl_s),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .wr_en      (wr_en),
  .ptr        (ptr)
);

// File: tb/cfgbus_target_test.sv
module cfgbus_target_test;

  localparam logic [6:0] ADDR = 7'h58;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  wire  sda_pull;
  wire  pd, oe;
  wire  [127:0] cfg;
  wire  sda_line = m_sda & !sda_pull;

  always #2.5 clk = ~clk;

  cfgbus_target #(.TARGET_ADDR(ADDR)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pd_scl_i(scl), .oe_sda_i(sda_line),
    .sda_pull_o(sda_pull), .pd_o(pd), .oe_o(oe), .cfg_o(cfg)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int run_pulls = 0;
  int high_changes = 0;
  logic prev_pull = 1'b0;
  logic [7:0] model [16];
  logic [7:0] wbuf [4];

  always @(negedge clk) begin
    cycles++;
    if (mode && sda_pull) run_pulls++;
    if (rst_n && !mode && (sda_pull != prev_pull) && scl) high_changes++;
    prev_pull = sda_pull;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] packed_model();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); m_sda = 1'b0; waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(Q); scl = 1'b1; waitq(Q); m_sda = 1'b1; waitq(Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; waitq(Q); scl = 1'b1; waitq(2*Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; waitq(Q); scl = 1'b1; waitq(Q); b = sda_line; waitq(Q); scl = 1'b0; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(!give_ack);
  endtask

  // write n bytes from wbuf starting at pointer p, checking every acknowledge
  task automatic write_txn(input logic [3:0] p, input int n, input string req);
    logic a;
    logic [3:0] q;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, 1, {req, " R3 addr ack"});
    send_byte({4'h0, p}, a);    check(a, 1, {req, " R4 ptr ack"});
    q = p;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); check(a, 1, {req, " R4 data ack"});
      model[q] = wbuf[i];
      q = q + 4'd1;
    end
    bus_stop();
  endtask

  localparam logic [11:0] VEC [6] = '{
    {4'h2, 8'hA5}, {4'h0, 8'h3C}, {4'hF, 8'h81},
    {4'h7, 8'hFF}, {4'h9, 8'h01}, {4'h2, 8'h5A}
  };

  initial begin
    logic a;
    logic [7:0] r;
    for (int k = 0; k < 16; k++) model[k] = 8'h00;
    waitq(5);
    rst_n = 1'b1;
    waitq(5);

    // reset state
    check(cfg, 128'h0, "R8 reset store");
    check({pd, oe}, 2'b00, "R1 program-mode controls");
    check(sda_pull, 0, "R9 idle no pull");

    // vector table: single write then repeated-start readback
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_txn(VEC[v][11:8], 1, "vec");
      check(cfg, packed_model(), "R8 store mapping");
      bus_start();
      send_byte({ADDR, 1'b0}, a);          check(a, 1, "R3 addr ack");
      send_byte({4'h0, VEC[v][11:8]}, a);  check(a, 1, "R4 ptr ack");
      bus_start();
      send_byte({ADDR, 1'b1}, a);          check(a, 1, "R7 repeated start read addr");
      recv_byte(1'b0, r);                  check(r, VEC[v][7:0], "R6 readback");
      bus_stop();
    end

    // write burst across the wrap point
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_txn(4'hE, 3, "wrap");
    check(cfg, packed_model(), "R5 write wrap 14,15,0");

    // read burst across the wrap point
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h0F, a);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    recv_byte(1'b1, r); check(r, model[15], "R6 read byte 15");
    recv_byte(1'b0, r); check(r, model[0],  "R5 read wrap byte 0");
    bus_stop();
    check(sda_pull, 0, "R6 released after nack");

    // wrong address: no ack and no write
    bus_start();
    send_byte({7'h23, 1'b0}, a); check(a, 0, "R3 foreign address nack");
    send_byte(8'h04, a);         check(a, 0, "R3 no ack after miss");
    send_byte(8'hEE, a);
    bus_stop();
    check(cfg, packed_model(), "R3 store untouched");

    // START inside a byte drops it
    bus_start();
    send_byte({ADDR, 1'b0}, a); send_byte(8'h03, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, 1, "R7 restart addr ack");
    send_byte(8'h05, a);
    send_byte(8'h77, a);
    bus_stop();
    model[5] = 8'h77;
    check(cfg, packed_model(), "R7 partial byte dropped");

    // run mode: pins become level controls
    mode = 1'b1;
    scl = 1'b1; m_sda = 1'b0; waitq(5);
    check({pd, oe}, 2'b10, "R1 run pd=1 oe=0");
    scl = 1'b0; m_sda = 1'b1; waitq(5);
    check({pd, oe}, 2'b01, "R1 run pd=0 oe=1");
    scl = 1'b1; waitq(5);
    wbuf[0] = 8'hC3;
    bus_start();
    send_byte({ADDR, 1'b0}, a); check(a, 0, "R2 run no ack");
    send_byte(8'h01, a);
    send_byte(8'hC3, a);
    bus_stop();
    check(cfg, packed_model(), "R2 run store unchanged");
    check(run_pulls, 0, "R2 no pull in run mode");
    scl = 1'b1; m_sda = 1'b1; waitq(5);
    mode = 1'b0; waitq(5);
    check({pd, oe}, 2'b00, "R1 back to program mode");

    // bus still works after mode change
    wbuf[0] = 8'h9E;
    write_txn(4'h1, 1, "post");
    check(cfg, packed_model(), "R4 write after mode change");

    check(high_changes, 0, "R9 pull edges only with clock low");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule